// File: doc/BRIEF.md
# SPI Serial Memory Slave

This block is the bus-side front end of a byte-addressable nonvolatile-style memory with no page buffer. It works as an SPI slave in mode 0. It decodes a small command set, collects a two-byte start address and then moves data bytes in either direction, one per eight SCK cycles, for as long as the master keeps chip select low. A byte-wide synchronous port on the far side reaches the storage array. Every write data byte goes to the array as soon as its last bit arrives, so a burst has no length limit. An internal address counter steps once per byte and wraps at the top of the array.

All bus pins are oversampled in the system clock domain. Each pin passes through a synchronizer, and the SCK edges are found by comparing the synchronized samples. The command controller is a single state machine with the following states:

- `ST_IDLE`: chip select is high.
- `ST_OPCODE`: the first byte is being collected.
- `ST_WREN`: a write-enable opcode has been seen, and the frame waits for CS to rise.
- `ST_ADDR_HI` / `ST_ADDR_LO`: the two address bytes are being collected.
- `ST_DUMMY`: the latency byte of a fast read.
- `ST_WR_DATA` / `ST_RD_DATA`: the data bursts.
- `ST_SKIP`: an unknown or refused opcode. Everything up to CS rise is ignored.

The transitions are:

- A synchronized CS rise moves any state to `ST_IDLE`.
- `ST_IDLE` moves to `ST_OPCODE` while CS is low.
- `ST_OPCODE` moves on a completed byte:
  - to `ST_WREN` for the write-enable opcode,
  - to `ST_ADDR_HI` for READ, FAST READ, or WRITE when the enable latch is set,
  - to `ST_SKIP` for anything else.
- `ST_ADDR_HI` moves to `ST_ADDR_LO` on a completed byte.
- `ST_ADDR_LO` moves on a completed byte to `ST_WR_DATA`, `ST_DUMMY` or `ST_RD_DATA`, chosen by the command.
- `ST_DUMMY` moves to `ST_RD_DATA` on a completed byte.

A write-protect window covers every address at or above `wp_base` while `wp_en` is high. The master must keep each SCK half period at least 6 `clk` cycles long.

Top module: `spi_serial_mem_slave`

## Requirements
- R1: Opcodes are shifted MSB first and sampled on rising SCK. 06h sets up write enable, 02h is WRITE, 03h is READ and 0Bh is FAST READ.
- R2: The write-enable latch is set only when CS rises on a frame whose opcode was 06h. A WRITE given while the latch is clear changes no array byte, and so does a 02h that follows 06h inside the same frame.
- R3: The latch is cleared when CS rises to end an accepted WRITE. A second WRITE without a new 06h frame changes nothing.
- R4: After the opcode come two address bytes, high byte first. Only the low ADDR_W bits of this 16-bit value are used, and the rest are discarded.
- R5: Each write data byte is stored once its eighth bit has been sampled. A data byte cut short by CS rise is not stored.
- R6: The address counter advances by one per data byte in both directions and wraps from 2^ADDR_W-1 to 0.
- R7: With `wp_en` high, a write data byte whose address is at or above `wp_base` is not stored and the counter stops. All later bytes of that burst are dropped, even if a wrap would have reached unprotected space.
- R8: In a READ, SO carries the first data byte MSB first, starting at the SCK fall after the last address bit. SI is ignored while data is being read out.
- R9: FAST READ inserts one dummy byte of 8 SCK cycles after the address and otherwise returns the same data as READ.
- R10: SO is enabled (`spi_so_oe` high) only during the data phase of a read. It is released within 5 `clk` cycles of CS going high, and it is released after reset.
- R11: An unknown opcode never enables SO and never writes the array until CS rises.
- R12: The protect window does not affect reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_si | input | 1 | Serial data from master |
| spi_so | output | 1 | Serial data to master |
| spi_so_oe | output | 1 | Output enable for SO; low means high impedance |
| wp_en | input | 1 | Enables the write-protect window |
| wp_base | input | ADDR_W | Lowest protected address |
| mem_addr | output | ADDR_W | Array address for read or write |
| mem_wdata | output | 8 | Array write data |
| mem_we | output | 1 | Array write strobe, one cycle per byte |
| mem_re | output | 1 | Array read strobe; data expected one cycle later |
| mem_rdata | input | 8 | Array read data |

## Verification
The bench builds the block with ADDR_W = 6, so the array has only 64 bytes. At that size, whole-array bursts with a wrap can be written and read back within a few thousand SCK cycles. Because the address is this narrow, the whole high address byte is discarded, and the bench checks this by sending nonzero high bytes. Protect-window freezing is tested with a burst that starts inside the window just below the top of the array. A counter that kept advancing would wrap into unprotected bytes, so freezing and mere skipping give different results at the low addresses.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_WREN,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_DUMMY,
        ST_WR_DATA,
        ST_RD_DATA,
        ST_SKIP
    } fsm_state_t;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_WRITE,
        CMD_READ,
        CMD_FAST
    } cmd_kind_t;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_FAST  = 8'h0B;

endpackage

// File: rtl/spi_pin_sync.sv
// Brings CS, SCK and SI into the clk domain and detects SCK/CS edges.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic si_i,
    output logic cs_active,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s
);

    logic [STAGES-1:0] cs_pipe;
    logic [STAGES-1:0] sck_pipe;
    logic [STAGES-1:0] si_pipe;
    logic              cs_last;
    logic              sck_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_pipe  <= '1;
            sck_pipe <= '0;
            si_pipe  <= '0;
            cs_last  <= 1'b1;
            sck_last <= 1'b0;
        end else begin
            cs_pipe  <= {cs_pipe[STAGES-2:0], cs_n_i};
            sck_pipe <= {sck_pipe[STAGES-2:0], sck_i};
            si_pipe  <= {si_pipe[STAGES-2:0], si_i};
            cs_last  <= cs_pipe[STAGES-1];
            sck_last <= sck_pipe[STAGES-1];
        end
    end

    assign cs_active = !cs_pipe[STAGES-1];
    assign cs_rise   = cs_pipe[STAGES-1] && !cs_last;
    assign sck_rise  = cs_active && sck_pipe[STAGES-1] && !sck_last;
    assign sck_fall  = cs_active && !sck_pipe[STAGES-1] && sck_last;
    assign si_s      = si_pipe[STAGES-1];

endmodule

// File: rtl/spi_rx_byte.sv
// Collects bits MSB first on each strobe; flags each completed byte.
module spi_rx_byte (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_active,
    input  logic       bit_strobe,
    input  logic       bit_in,
    output logic [2:0] bit_idx,
    output logic       byte_valid,
    output logic [7:0] byte_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx    <= 3'd0;
            byte_valid <= 1'b0;
            byte_data  <= 8'h00;
        end else if (!cs_active) begin
            bit_idx    <= 3'd0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (bit_strobe) begin
                byte_data <= {byte_data[6:0], bit_in};
                bit_idx   <= bit_idx + 3'd1;
                if (bit_idx == 3'd7) begin
                    byte_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_tx_byte.sv
// Drives SO MSB first; loads a new byte on the fall at each byte boundary.
module spi_tx_byte (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_active,
    input  logic       enable,
    input  logic       shift_edge,
    input  logic       at_boundary,
    input  logic [7:0] load_data,
    output logic       so_bit,
    output logic       so_en,
    output logic       load_taken
);

    logic [7:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= 8'h00;
            so_en      <= 1'b0;
            load_taken <= 1'b0;
        end else if (!cs_active) begin
            shreg      <= 8'h00;
            so_en      <= 1'b0;
            load_taken <= 1'b0;
        end else begin
            load_taken <= 1'b0;
            if (enable && shift_edge) begin
                if (at_boundary) begin
                    shreg      <= load_data;
                    so_en      <= 1'b1;
                    load_taken <= 1'b1;
                end else begin
                    shreg <= {shreg[6:0], 1'b0};
                end
            end
        end
    end

    assign so_bit = shreg[7];

endmodule

// File: rtl/spi_serial_mem_slave.sv
module spi_serial_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W      = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_si,
    output logic              spi_so,
    output logic              spi_so_oe,
    input  logic              wp_en,
    input  logic [ADDR_W-1:0] wp_base,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [7:0]        mem_rdata
);

    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(1);

    // ---------------- pin front end ----------------
    logic cs_active, cs_rise, sck_rise, sck_fall, si_s;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_i    (spi_cs_n),
        .sck_i     (spi_sck),
        .si_i      (spi_si),
        .cs_active (cs_active),
        .cs_rise   (cs_rise),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .si_s      (si_s)
    );

    logic [2:0] bit_idx;
    logic       byte_valid;
    logic [7:0] byte_data;

    spi_rx_byte u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_active  (cs_active),
        .bit_strobe (sck_rise),
        .bit_in     (si_s),
        .bit_idx    (bit_idx),
        .byte_valid (byte_valid),
        .byte_data  (byte_data)
    );

    // ---------------- controller state ----------------
    fsm_state_t        state, state_nxt;
    cmd_kind_t         cmd_q;
    logic              wel_q;
    logic              wel_clr_pend;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] mem_addr_q;
    logic [7:0]        mem_wdata_q;
    logic              mem_we_q;
    logic              mem_re_q;
    logic              rd_pending;
    logic [7:0]        prefetch_q;
    logic              load_taken;
    logic              tx_so_bit;
    logic              tx_so_en;
    logic [ADDR_W-1:0] addr_from_bytes;
    logic              addr_protected;

    // Address assembly: wide arrays keep part of the high byte, narrow ones drop it.
    generate
        if (ADDR_W > 8) begin : g_wide_addr
            logic [ADDR_W-9:0] hi_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hi_q <= '0;
                end else if (state == ST_ADDR_HI && byte_valid) begin
                    hi_q <= byte_data[ADDR_W-9:0];
                end
            end
            assign addr_from_bytes = {hi_q, byte_data};
        end else begin : g_narrow_addr
            assign addr_from_bytes = byte_data[ADDR_W-1:0];
        end
    endgenerate

    assign addr_protected = wp_en && (addr_q >= wp_base);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nxt = state;
        if (!cs_active) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_nxt = ST_OPCODE;
                end
                ST_OPCODE: begin
                    if (byte_valid) begin
                        if (byte_data == OP_WREN) begin
                            state_nxt = ST_WREN;
                        end else if (byte_data == OP_WRITE) begin
                            state_nxt = wel_q ? ST_ADDR_HI : ST_SKIP;
                        end else if (byte_data == OP_READ || byte_data == OP_FAST) begin
                            state_nxt = ST_ADDR_HI;
                        end else begin
                            state_nxt = ST_SKIP;
                        end
                    end
                end
                ST_ADDR_HI: begin
                    if (byte_valid) begin
                        state_nxt = ST_ADDR_LO;
                    end
                end
                ST_ADDR_LO: begin
                    if (byte_valid) begin
                        if (cmd_q == CMD_WRITE) begin
                            state_nxt = ST_WR_DATA;
                        end else if (cmd_q == CMD_FAST) begin
                            state_nxt = ST_DUMMY;
                        end else begin
                            state_nxt = ST_RD_DATA;
                        end
                    end
                end
                ST_DUMMY: begin
                    if (byte_valid) begin
                        state_nxt = ST_RD_DATA;
                    end
                end
                ST_WREN, ST_WR_DATA, ST_RD_DATA, ST_SKIP: begin
                    state_nxt = state;
                end
            endcase
        end
    end

    // ---------------- outputs and datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q        <= CMD_NONE;
            wel_q        <= 1'b0;
            wel_clr_pend <= 1'b0;
            addr_q       <= '0;
            mem_addr_q   <= '0;
            mem_wdata_q  <= 8'h00;
            mem_we_q     <= 1'b0;
            mem_re_q     <= 1'b0;
            rd_pending   <= 1'b0;
            prefetch_q   <= 8'h00;
        end else begin
            mem_we_q   <= 1'b0;
            mem_re_q   <= 1'b0;
            rd_pending <= mem_re_q;
            if (rd_pending) begin
                prefetch_q <= mem_rdata;
            end

            // Write-enable latch changes only at the end of a frame.
            if (cs_rise) begin
                if (state == ST_WREN) begin
                    wel_q <= 1'b1;
                end else if (wel_clr_pend) begin
                    wel_q <= 1'b0;
                end
                wel_clr_pend <= 1'b0;
            end

            if (state == ST_OPCODE && byte_valid) begin
                if (byte_data == OP_WRITE && wel_q) begin
                    cmd_q        <= CMD_WRITE;
                    wel_clr_pend <= 1'b1;
                end else if (byte_data == OP_READ) begin
                    cmd_q <= CMD_READ;
                end else if (byte_data == OP_FAST) begin
                    cmd_q <= CMD_FAST;
                end else begin
                    cmd_q <= CMD_NONE;
                end
            end

            if (state == ST_ADDR_LO && byte_valid) begin
                addr_q <= addr_from_bytes;
                if (cmd_q == CMD_READ) begin
                    mem_addr_q <= addr_from_bytes;
                    mem_re_q   <= 1'b1;
                end
            end

            if (state == ST_DUMMY && byte_valid) begin
                mem_addr_q <= addr_q;
                mem_re_q   <= 1'b1;
            end

            // Commit each whole byte; a protected address freezes the counter.
            if (state == ST_WR_DATA && byte_valid && !addr_protected) begin
                mem_we_q    <= 1'b1;
                mem_addr_q  <= addr_q;
                mem_wdata_q <= byte_data;
                addr_q      <= addr_q + ADDR_STEP;
            end

            // The byte just handed to SO came from addr_q; fetch the next one.
            if (state == ST_RD_DATA && load_taken) begin
                addr_q     <= addr_q + ADDR_STEP;
                mem_addr_q <= addr_q + ADDR_STEP;
                mem_re_q   <= 1'b1;
            end
        end
    end

    spi_tx_byte u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_active   (cs_active),
        .enable      (state == ST_RD_DATA),
        .shift_edge  (sck_fall),
        .at_boundary (bit_idx == 3'd0),
        .load_data   (prefetch_q),
        .so_bit      (tx_so_bit),
        .so_en       (tx_so_en),
        .load_taken  (load_taken)
    );

    assign spi_so    = tx_so_en ? tx_so_bit : 1'b0;
    assign spi_so_oe = tx_so_en;
    assign mem_addr  = mem_addr_q;
    assign mem_wdata = mem_wdata_q;
    assign mem_we    = mem_we_q;
    assign mem_re    = mem_re_q;

endmodule

// File: rtl/spi_mem_checker.sv
module spi_mem_checker #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              spi_so_oe,
    input logic              wp_en,
    input logic [ADDR_W-1:0] wp_base,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_re
);

    logic [2:0] cs_hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_hi_cnt <= 3'd7;
        end else if (!spi_cs_n) begin
            cs_hi_cnt <= 3'd0;
        end else if (cs_hi_cnt != 3'd7) begin
            cs_hi_cnt <= cs_hi_cnt + 3'd1;
        end
    end

    // R10: SO released soon after chip select rises
    p_so_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi_cnt >= 3'd5) |-> !spi_so_oe);

    // R5: array writes only happen inside a frame
    p_we_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (cs_hi_cnt < 3'd6));

    // R5: one write strobe per completed byte
    p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R7: never write inside the protected window
    p_no_prot_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !(wp_en && (mem_addr >= wp_base)));

    // R8: read strobes are single-cycle and never collide with writes
    p_re_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_re);

    p_we_re_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

endmodule

bind spi_serial_mem_slave spi_mem_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (spi_cs_n),
    .spi_so_oe (spi_so_oe),
    .wp_en     (wp_en),
    .wp_base   (wp_base),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re)
);

// File: tb/spi_serial_mem_slave_bench.sv
`timescale 1ns/1ps
module spi_serial_mem_slave_bench;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam int HALF  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          sck = 1'b0;
    logic          si = 1'b0;
    logic          wp_en = 1'b0;
    logic [AW-1:0] wp_base = '0;
    logic          so, so_oe;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          mem_we, mem_re;
    logic [7:0]    mem_rdata = 8'h00;

    logic [7:0] arr    [DEPTH];
    logic [7:0] ref_m  [DEPTH];
    logic [7:0] wbuf   [128];
    logic [7:0] rbuf   [128];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit oe_seen = 0;

    always #4 clk = ~clk;

    spi_serial_mem_slave #(.ADDR_W(AW)) u_spi_serial_mem_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_cs_n  (cs_n),
        .spi_sck   (sck),
        .spi_si    (si),
        .spi_so    (so),
        .spi_so_oe (so_oe),
        .wp_en     (wp_en),
        .wp_base   (wp_base),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_rdata (mem_rdata)
    );

    // Array model: synchronous, one-cycle read latency
    always @(posedge clk) begin
        if (mem_we) arr[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= arr[mem_addr];
    end

    always @(posedge clk) if (so_oe) oe_seen <= 1'b1;

    task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i >= 8 - nbits; i--) begin
            si = tx[i];
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            rx[i] = so;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx);
        logic [7:0] dummy;
        xfer_bits(tx, 8, dummy);
    endtask

    task automatic frame_begin();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic frame_end();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (6 * HALF) @(negedge clk);
    endtask

    task automatic wren_frame();
        frame_begin();
        xfer(8'h06);
        frame_end();
    endtask

    // Read n bytes into rbuf; SI carries junk during data (R8)
    task automatic spi_read(input logic [7:0] op, input logic [15:0] a, input int n);
        logic [7:0] r;
        frame_begin();
        xfer(op);
        xfer(a[15:8]);
        xfer(a[7:0]);
        if (op == 8'h0B) xfer(8'hA5);
        for (int i = 0; i < n; i++) begin
            xfer_bits(8'hFF ^ 8'(i * 3), 8, r);
            rbuf[i] = r;
        end
        frame_end();
        check(!so_oe, "R10", so_oe, 0, "so_oe after read frame");
    endtask

    task automatic spi_write(input logic [15:0] a, input int n, input int extra_bits);
        logic [7:0] r;
        frame_begin();
        xfer(8'h02);
        xfer(a[15:8]);
        xfer(a[7:0]);
        for (int i = 0; i < n; i++) xfer(wbuf[i]);
        if (extra_bits > 0) xfer_bits(8'hC3, extra_bits, r);
        frame_end();
    endtask

    // Expected effect of an accepted write burst (R5, R6, R7)
    task automatic model_write(input int start, input int n);
        for (int i = 0; i < n; i++) begin
            int ad;
            ad = (start + i) % DEPTH;
            if (wp_en && ad >= int'(wp_base)) break;
            ref_m[ad] = wbuf[i];
        end
    endtask

    task automatic verify_read(input string req, input logic [7:0] op, input int start, input int n);
        oe_seen = 1'b0;
        spi_read(op, 16'(start) | 16'hC000, n);
        check(oe_seen, req, oe_seen, 1, "so_oe during data");
        for (int i = 0; i < n; i++) begin
            int ad;
            ad = (start + i) % DEPTH;
            check(rbuf[i] == ref_m[ad], req, rbuf[i], ref_m[ad], $sformatf("byte at %0d", ad));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) begin
            arr[a]   = 8'((a * 37 + 11) & 255);
            ref_m[a] = 8'((a * 37 + 11) & 255);
        end
        repeat (10) @(negedge clk);
        check(!so_oe, "R10", so_oe, 0, "so_oe in reset");
        check(!mem_we, "R5", mem_we, 0, "mem_we in reset");
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check(!so_oe, "R10", so_oe, 0, "so_oe after reset");

        // R8, R4: plain read, high address byte discarded
        verify_read("R8", 8'h03, 5, 4);
        // R6: read wraps at the top
        verify_read("R6", 8'h03, 62, 5);
        // R9: fast read with dummy byte
        verify_read("R9", 8'h0B, 10, 3);

        // R2: WRITE without the latch
        wbuf[0] = 8'hAA;
        spi_write(16'd20, 1, 0);
        verify_read("R2", 8'h03, 20, 1);

        // R2: 06h and 02h in the same frame does not enable the write
        frame_begin();
        xfer(8'h06); xfer(8'h02); xfer(8'h00); xfer(8'd21); xfer(8'hBB);
        frame_end();
        verify_read("R2", 8'h03, 21, 1);

        // R1, R5, R6: enabled burst wrapping past the top
        wren_frame();
        for (int i = 0; i < 4; i++) wbuf[i] = 8'h10 + 8'(i);
        spi_write(16'hFF00 | 16'd61, 4, 0);
        model_write(61, 4);
        verify_read("R1", 8'h03, 60, 6);

        // R3: latch cleared by the previous write
        wbuf[0] = 8'h77;
        spi_write(16'd5, 1, 0);
        verify_read("R3", 8'h03, 5, 1);

        // R5: trailing partial byte is dropped
        wren_frame();
        wbuf[0] = 8'h3C;
        spi_write(16'd30, 1, 4);
        model_write(30, 1);
        verify_read("R5", 8'h03, 30, 2);

        // R7: burst into the protected window stops there
        wp_en = 1'b1;
        wp_base = AW'(40);
        wren_frame();
        for (int i = 0; i < 6; i++) wbuf[i] = 8'hE0 + 8'(i);
        spi_write(16'd37, 6, 0);
        model_write(37, 6);
        verify_read("R7", 8'h03, 36, 8);

        // R7: a frozen counter does not wrap into unprotected space
        wren_frame();
        for (int i = 0; i < 4; i++) wbuf[i] = 8'h90 + 8'(i);
        spi_write(16'd62, 4, 0);
        model_write(62, 4);
        verify_read("R7", 8'h03, 62, 4);

        // R12: reads inside the window still work
        verify_read("R12", 8'h0B, 41, 3);
        wp_en = 1'b0;

        // R11: unknown opcode
        oe_seen = 1'b0;
        frame_begin();
        xfer(8'h55); xfer(8'h00); xfer(8'd3); xfer(8'h12);
        frame_end();
        check(!oe_seen, "R11", oe_seen, 0, "so_oe after unknown opcode");
        verify_read("R11", 8'h03, 0, 8);

        // Sweep: whole-array burst write with wrap, then read back twice
        wren_frame();
        for (int i = 0; i < DEPTH + 2; i++) wbuf[i] = 8'(((i % DEPTH) * 13 + 5) ^ 8'h5A);
        spi_write(16'd0, DEPTH + 2, 0);
        model_write(0, DEPTH + 2);
        verify_read("R6", 8'h03, 0, DEPTH + 3);
        verify_read("R9", 8'h0B, 32, DEPTH);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule